// File: doc/BRIEF.md
# Single-Precision Float to Unsigned Integer Converter

This unit takes one IEEE-754 single-precision value per accepted input and returns its value as a 32-bit unsigned integer. Rounding is always toward zero, so any fraction is dropped. Next to the integer it reports two flags: invalid and inexact. It also drives one of two strobes toward a processor status word. The flag-write strobe means "merge the raised flags into status". The summary-clear strobe means "no flag was raised, so clear the summary status bit".

The unit has one register stage. An operand offered with `in_valid` high gives its result, flags and strobe on the next cycle, with `out_valid` high. A decoder sorts the operand into one of six categories: ZERO, POS_SUB, POS_NORM, POS_INF, NEG and NAN. An aligner shifts the 24-bit significand, which includes the hidden one, into integer position. The top selects the outputs with a case on the category.

The special cases follow fixed rules:
- Every NaN gives zero.
- Every value below zero gives zero and is invalid only.
- Invalid always masks inexact.
- Negative zero behaves like positive zero.

Top module: `fp32_to_u32_trunc`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was high and low otherwise. The result and flag outputs change only on a cycle after an accepted input.
- R2: A positive normal operand below 2^32 produces its value truncated toward zero. Example: 1.0 (0x3F800000) gives 1.
- R3: A positive in-range operand with a non-zero fraction sets inexact. This includes positive denormals and values below 1.0, which give 0. Example: 3.75 (0x40700000) gives 3 with inexact.
- R4: Any NaN, quiet or signalling, of either sign, gives 0 with invalid=1 and inexact=0. A NaN has exponent field bits 30:23 all ones and a non-zero fraction in bits 22:0.
- R5: Any operand below zero gives 0 with invalid=1 and inexact=0. This covers negative denormals, -0.5, -1.0 and below, and negative infinity. The sign is bit 31.
- R6: Positive zero (0x00000000) and negative zero (0x80000000) both give 0 with no flag.
- R7: A positive operand of 2^32 or more, or positive infinity, gives 0xFFFFFFFF with invalid=1 and inexact=0.
- R8: On each output cycle exactly one strobe is high. `flag_write` is high when invalid or inexact is set, and `summary_clear` is high when neither is set. Both strobes are low when `out_valid` is low.
- R9: After reset, `out_valid`, both strobes, both flags and the result are all 0.
- R10: A positive operand with unbiased exponent between 23 and 31 is exact and is shifted left. For example 0x4F000000 gives 0x80000000, and 0x4F7FFFFF gives 0xFFFFFF00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Unsigned integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| flag_write | output | 1 | Merge the raised flags into the status word |
| summary_clear | output | 1 | Clear the status summary bit |

## Verification
The operands cover every category and every shift direction:
- exact small integers;
- values with a fraction one bit below the binary point;
- pure fractions and denormals;
- the largest representable value below 2^32, and 2^32 itself;
- both infinities;
- quiet, signalling and negative NaNs;
- both zeros.

Each case separates one output rule from its neighbours:
- -0.5 against -0.0 shows that the sign test is not applied to zero.
- 2^32 against 0x4F7FFFFF marks the saturation edge.
- A fraction just above 2^22 shows whether the bits shifted out reach inexact.

Gap cycles with `in_valid` low show that the outputs hold and that the strobes stay quiet.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
    typedef enum logic [2:0] {
        CLS_ZERO     = 3'd0,
        CLS_POS_SUB  = 3'd1,
        CLS_POS_NORM = 3'd2,
        CLS_POS_INF  = 3'd3,
        CLS_NEG      = 3'd4,
        CLS_NAN      = 3'd5
    } opclass_t;
endpackage

// File: rtl/f2u_sort.sv
module f2u_sort #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic             sign,
    input  logic [EXP_W-1:0] exp_f,
    input  logic [MAN_W-1:0] man_f,
    output f2u_pkg::opclass_t cls
);
    import f2u_pkg::*;

    logic exp_ones, exp_zero, man_zero;

    always_comb begin
        exp_ones = &exp_f;
        exp_zero = ~|exp_f;
        man_zero = ~|man_f;
        if (exp_ones && !man_zero)
            cls = CLS_NAN;
        else if (exp_zero && man_zero)
            cls = CLS_ZERO;
        else if (sign)
            cls = CLS_NEG;
        else if (exp_ones)
            cls = CLS_POS_INF;
        else if (exp_zero)
            cls = CLS_POS_SUB;
        else
            cls = CLS_POS_NORM;
    end
endmodule

// File: rtl/f2u_align.sv
module f2u_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int OUT_W = 32
) (
    input  logic [EXP_W-1:0] exp_f,
    input  logic [MAN_W-1:0] man_f,
    output logic [OUT_W-1:0] mag,
    output logic             frac_lost,
    output logic             too_big
);
    localparam int SIG_W = MAN_W + 1;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int POINT = BIAS + MAN_W;
    localparam int TOP_E = BIAS + OUT_W;

    logic [SIG_W-1:0]   sig;
    logic [2*SIG_W-1:0] wide;
    logic [EXP_W-1:0]   rs;
    logic [EXP_W-1:0]   ls;

    always_comb begin
        sig       = {1'b1, man_f};
        mag       = '0;
        frac_lost = 1'b0;
        too_big   = 1'b0;
        wide      = '0;
        rs        = '0;
        ls        = '0;
        if (exp_f >= EXP_W'(TOP_E)) begin
            too_big = 1'b1;
            mag     = '1;
        end else if (exp_f >= EXP_W'(POINT)) begin
            ls  = exp_f - EXP_W'(POINT);
            mag = OUT_W'(sig) << ls;
        end else if (exp_f >= EXP_W'(BIAS)) begin
            rs        = EXP_W'(POINT) - exp_f;
            wide      = {sig, {SIG_W{1'b0}}} >> rs;
            mag       = OUT_W'(wide[2*SIG_W-1:SIG_W]);
            frac_lost = |wide[SIG_W-1:0];
        end else begin
            frac_lost = 1'b1;
        end
    end

    // R10
    always_comb begin
        if (exp_f >= EXP_W'(POINT))
            left_exact_chk: assert (!frac_lost);
    end
endmodule

// File: rtl/fp32_to_u32_trunc.sv
module fp32_to_u32_trunc #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int OUT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [EXP_W+MAN_W:0]   in_operand,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_result,
    output logic                   out_invalid,
    output logic                   out_inexact,
    output logic                   flag_write,
    output logic                   summary_clear
);
    import f2u_pkg::*;

    localparam int IN_W = EXP_W + MAN_W + 1;

    logic             op_sign;
    logic [EXP_W-1:0] op_exp;
    logic [MAN_W-1:0] op_man;
    opclass_t         cls;
    logic [OUT_W-1:0] mag;
    logic             frac_lost;
    logic             too_big;

    logic [OUT_W-1:0] nx_result;
    logic             nx_invalid;
    logic             nx_inexact;

    assign op_sign = in_operand[IN_W-1];
    assign op_exp  = in_operand[IN_W-2:MAN_W];
    assign op_man  = in_operand[MAN_W-1:0];

    f2u_sort #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sort (
        .sign  (op_sign),
        .exp_f (op_exp),
        .man_f (op_man),
        .cls   (cls)
    );

    f2u_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_W(OUT_W)) u_align (
        .exp_f     (op_exp),
        .man_f     (op_man),
        .mag       (mag),
        .frac_lost (frac_lost),
        .too_big   (too_big)
    );

    always_comb begin
        nx_result  = '0;
        nx_invalid = 1'b0;
        nx_inexact = 1'b0;
        unique case (cls)
            CLS_ZERO: ;
            CLS_POS_SUB: nx_inexact = 1'b1;
            CLS_POS_NORM: begin
                if (too_big) begin
                    nx_result  = '1;
                    nx_invalid = 1'b1;
                end else begin
                    nx_result  = mag;
                    nx_inexact = frac_lost;
                end
            end
            CLS_POS_INF: begin
                nx_result  = '1;
                nx_invalid = 1'b1;
            end
            CLS_NEG, CLS_NAN: nx_invalid = 1'b1;
            default: nx_invalid = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_result    <= '0;
            out_invalid   <= 1'b0;
            out_inexact   <= 1'b0;
            flag_write    <= 1'b0;
            summary_clear <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            flag_write    <= in_valid & (nx_invalid | nx_inexact);
            summary_clear <= in_valid & ~(nx_invalid | nx_inexact);
            if (in_valid) begin
                out_result  <= nx_result;
                out_invalid <= nx_invalid;
                out_inexact <= nx_inexact;
            end
        end
    end

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_invalid) && !out_valid);
    // R8
    strobe_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({flag_write, summary_clear}));
    // R8
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !flag_write && !summary_clear);
    // R4
    nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&op_exp) && (|op_man)) |=>
            out_result == '0 && out_invalid && !out_inexact);
    // R5
    neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sign && (|in_operand[IN_W-2:0])) |=>
            out_result == '0 && out_invalid);
    // R7
    inv_masks_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> !out_inexact);
endmodule

// File: tb/tb_fp32_to_u32_trunc.sv
`timescale 1ns/1ps
module tb_fp32_to_u32_trunc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic        out_valid, out_invalid, out_inexact, flag_write, summary_clear;
    logic [31:0] out_result;
    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fp32_to_u32_trunc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
        .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
        .out_inexact(out_inexact), .flag_write(flag_write), .summary_clear(summary_clear)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic convert(input string req, input logic [31:0] op,
                           input logic [31:0] res, input logic inv, input logic inx);
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        @(negedge clk);
        in_valid   = 1'b0;
        check({req, " out_valid"}, {31'd0, out_valid}, 32'd1);
        check({req, " result"}, out_result, res);
        check({req, " flags"}, {30'd0, out_invalid, out_inexact}, {30'd0, inv, inx});
        check("R8 strobes", {30'd0, flag_write, summary_clear},
              {30'd0, inv | inx, ~(inv | inx)});
    endtask

    task automatic gap_hold(input logic [31:0] res, input logic inv, input logic inx);
        in_operand = 32'h7FC0_0000;
        @(negedge clk);
        check("R1 idle valid", {31'd0, out_valid}, 32'd0);
        check("R1 held result", out_result, res);
        check("R1 held flags", {30'd0, out_invalid, out_inexact}, {30'd0, inv, inx});
        check("R8 idle strobes", {30'd0, flag_write, summary_clear}, 32'd0);
    endtask

    initial begin
        #1000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        #7;
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset result", out_result, 32'd0);
        check("R9 reset flags", {28'd0, out_invalid, out_inexact, flag_write, summary_clear}, 32'd0);
        rst_n = 1'b1;
        convert("R2 one", 32'h3F80_0000, 32'd1, 1'b0, 1'b0);
        convert("R2 2^24", 32'h4B80_0000, 32'h0100_0000, 1'b0, 1'b0);
        convert("R3 3.75", 32'h4070_0000, 32'd3, 1'b0, 1'b1);
        convert("R3 half lsb", 32'h4A80_0001, 32'h0040_0000, 1'b0, 1'b1);
        convert("R3 0.5", 32'h3F00_0000, 32'd0, 1'b0, 1'b1);
        convert("R3 denormal", 32'h0000_0001, 32'd0, 1'b0, 1'b1);
        gap_hold(32'd0, 1'b0, 1'b1);
        convert("R10 2^31", 32'h4F00_0000, 32'h8000_0000, 1'b0, 1'b0);
        convert("R10 max", 32'h4F7F_FFFF, 32'hFFFF_FF00, 1'b0, 1'b0);
        convert("R7 2^32", 32'h4F80_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
        convert("R7 huge", 32'h7F7F_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        convert("R7 +inf", 32'h7F80_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
        gap_hold(32'hFFFF_FFFF, 1'b1, 1'b0);
        convert("R4 qnan", 32'h7FC0_0000, 32'd0, 1'b1, 1'b0);
        convert("R4 snan", 32'h7F80_0001, 32'd0, 1'b1, 1'b0);
        convert("R4 neg nan", 32'hFFC0_0000, 32'd0, 1'b1, 1'b0);
        convert("R5 -0.5", 32'hBF00_0000, 32'd0, 1'b1, 1'b0);
        convert("R5 -1.0", 32'hBF80_0000, 32'd0, 1'b1, 1'b0);
        convert("R5 -inf", 32'hFF80_0000, 32'd0, 1'b1, 1'b0);
        convert("R5 neg denormal", 32'h8000_0001, 32'd0, 1'b1, 1'b0);
        convert("R6 +0", 32'h0000_0000, 32'd0, 1'b0, 1'b0);
        convert("R6 -0", 32'h8000_0000, 32'd0, 1'b0, 1'b0);
        convert("R2 after zero", 32'h4120_0000, 32'd10, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule